// File: doc/BRIEF.md
# Modular Exponentiation Engine

This block raises a 32-bit base to a 32-bit power modulo a 32-bit modulus. A single start strobe captures the base, the exponent and the modulus. The block then walks the exponent from its lowest bit to its highest, always visiting all 32 positions.

For every position it squares a running power of the base. When the bit is set, it first multiplies an accumulating result by that running power. Both operations share one bit-serial modular multiplier. This multiplier adds one partial product per cycle and reduces after each step, so no full-width product is ever formed.

The caller must keep the base below the modulus and use a modulus larger than one. While a run is in progress the block raises a busy flag. It marks completion with a single-cycle done pulse. The result stays on its output until the next completion replaces it.

Top module: `modexp_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, busy_o and done_o are 0 and result_o is 0.
- R2: A start_i sampled while idle makes busy_o 1 on the next cycle. done_o is high for exactly one cycle per run, and busy_o is 0 in that cycle.
- R3: At done_o, result_o equals base_i raised to exp_i modulo mod_i, using the operand values captured with the accepted start_i.
- R4: An exponent of 0 gives result_o = 1.
- R5: Every exponent position up to bit 31 contributes. An exponent with only bit 31 set, or with bits 31 and 0 set, gives the exact modular power.
- R6: The result update for a set bit uses the running power from before that bit's squaring. An exponent of 1 therefore returns the base unchanged.
- R7: A start_i raised while busy_o is 1 is ignored. The run in progress keeps its captured operands and finishes with its own result, and no extra done_o pulse appears.
- R8: result_o holds its value in every cycle in which done_o is 0, even when the inputs change without a start.
- R9: A modulus close to 2^32 (for example 0xFFFFFFFB) with operands close to it gives the exact result, with no overflow in the intermediate sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run; sampled only while idle |
| base_i | input | 32 | Base, must be below mod_i |
| exp_i | input | 32 | Exponent |
| mod_i | input | 32 | Modulus, must exceed 1 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Modular power, held between completions |

## Verification
Two events can coincide in the same cycle: a new start request and a run that is still in progress. The bench provokes this by raising start with fresh operands part way through a run. It then judges the outcome in two ways. The scoreboard must receive exactly one result, and that result must match the power of the operands captured first. The pairing of the done pulse with busy low is the other same-cycle relation. The monitor checks it at every completion.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [2:0] {
    XP_IDLE,
    XP_MUL_ACC,
    XP_SQUARE,
    XP_ADVANCE,
    XP_FINISH
  } xp_state_t;
endpackage

// File: rtl/modmul_serial.sv
// Bit-serial interleaved modular multiplier: one multiplier bit per cycle, MSB first.
module modmul_serial #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] m_i,
  output logic         done_o,
  output logic [W-1:0] p_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int AW = W + 2;

  logic [AW-1:0] acc;
  logic [W-1:0]  xs, yv, mv;
  logic [CW-1:0] cnt;
  logic          run;
  logic [AW-1:0] t1, t2, t3, mext;

  // Twice the accumulator plus an operand is below 3*2^W, so two extra bits suffice.
  always_comb begin
    mext = {2'b00, mv};
    t1   = {acc[AW-2:0], 1'b0} + (xs[W-1] ? {2'b00, yv} : '0);
    t2   = (t1 >= mext) ? t1 - mext : t1;
    t3   = (t2 >= mext) ? t2 - mext : t2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      xs     <= '0;
      yv     <= '0;
      mv     <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      done_o <= 1'b0;
      p_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !run) begin
        acc <= '0;
        xs  <= a_i;
        yv  <= b_i;
        mv  <= m_i;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        acc <= t3;
        xs  <= {xs[W-2:0], 1'b0};
        cnt <= cnt + CW'(1);
        if (cnt == CW'(W - 1)) begin
          run    <= 1'b0;
          done_o <= 1'b1;
          p_o    <= t3[W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/modexp_seq.sv
// Sequencer: walks exponent bits LSB first, issuing multiply-then-square per bit.
module modexp_seq
  import modexp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mod_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o,
  output logic         mm_start_o,
  output logic [W-1:0] mm_a_o,
  output logic [W-1:0] mm_b_o,
  output logic [W-1:0] mm_m_o,
  input  logic         mm_done_i,
  input  logic [W-1:0] mm_p_i
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  xp_state_t     state;
  logic [W-1:0]  acc_q, pw_q, ex_q, md_q;
  logic [CW-1:0] pos_q;
  logic          wait_q;

  // The accumulate step reads the power before this bit's squaring overwrites it.
  assign mm_a_o = (state == XP_MUL_ACC) ? acc_q : pw_q;
  assign mm_b_o = pw_q;
  assign mm_m_o = md_q;
  assign busy_o = (state != XP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= XP_IDLE;
      acc_q      <= '0;
      pw_q       <= '0;
      ex_q       <= '0;
      md_q       <= '0;
      pos_q      <= '0;
      wait_q     <= 1'b0;
      mm_start_o <= 1'b0;
      done_o     <= 1'b0;
      result_o   <= '0;
    end else begin
      mm_start_o <= 1'b0;
      done_o     <= 1'b0;
      unique case (state)
        XP_IDLE: begin
          if (start_i) begin
            acc_q  <= W'(1);
            pw_q   <= base_i;
            ex_q   <= exp_i;
            md_q   <= mod_i;
            pos_q  <= '0;
            wait_q <= 1'b0;
            state  <= exp_i[0] ? XP_MUL_ACC : XP_SQUARE;
          end
        end
        XP_MUL_ACC: begin
          if (!wait_q) begin
            mm_start_o <= 1'b1;
            wait_q     <= 1'b1;
          end else if (mm_done_i) begin
            acc_q  <= mm_p_i;
            wait_q <= 1'b0;
            state  <= XP_SQUARE;
          end
        end
        XP_SQUARE: begin
          if (!wait_q) begin
            mm_start_o <= 1'b1;
            wait_q     <= 1'b1;
          end else if (mm_done_i) begin
            pw_q   <= mm_p_i;
            wait_q <= 1'b0;
            state  <= XP_ADVANCE;
          end
        end
        XP_ADVANCE: begin
          ex_q  <= ex_q >> 1;
          pos_q <= pos_q + CW'(1);
          if (pos_q == CW'(W - 1)) state <= XP_FINISH;
          else state <= ex_q[1] ? XP_MUL_ACC : XP_SQUARE;
        end
        XP_FINISH: begin
          done_o   <= 1'b1;
          result_o <= acc_q;
          state    <= XP_IDLE;
        end
        default: state <= XP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/modexp_engine.sv
module modexp_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mod_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic         mm_start, mm_done;
  logic [W-1:0] mm_a, mm_b, mm_m, mm_p;

  modexp_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .base_i     (base_i),
    .exp_i      (exp_i),
    .mod_i      (mod_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .mm_start_o (mm_start),
    .mm_a_o     (mm_a),
    .mm_b_o     (mm_b),
    .mm_m_o     (mm_m),
    .mm_done_i  (mm_done),
    .mm_p_i     (mm_p)
  );

  modmul_serial #(.W(W)) u_mm (
    .clk     (clk),
    .rst     (rst),
    .start_i (mm_start),
    .a_i     (mm_a),
    .b_i     (mm_b),
    .m_i     (mm_m),
    .done_o  (mm_done),
    .p_o     (mm_p)
  );
endmodule

// File: rtl/modexp_engine_chk.sv
module modexp_engine_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_no_abort_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));
endmodule

bind modexp_engine modexp_engine_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/modexp_engine_bench.sv
module modexp_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0, exp_i = '0, mod_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] last_val = '0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #5 clk = ~clk;

  modexp_engine u_modexp_engine (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
    .exp_i(exp_i), .mod_i(mod_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  function automatic logic [31:0] ref_pow(logic [31:0] b, logic [31:0] e, logic [31:0] n);
    logic [63:0] r, s;
    r = 64'd1 % {32'd0, n};
    s = {32'd0, b} % {32'd0, n};
    for (int i = 0; i < 32; i++) begin
      if (e[i]) r = (r * s) % {32'd0, n};
      s = (s * s) % {32'd0, n};
    end
    return r[31:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: pops the scoreboard at every completion.
  always @(negedge clk) begin
    if (!rst && done_o) begin
      chk(busy_o == 1'b0, "R2", {31'd0, busy_o}, 32'd0);
      if (sbq.size() == 0) begin
        chk(1'b0, "R7", result_o, 32'hxxxxxxxx);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        chk(result_o == it.val, it.tag, result_o, it.val);
        last_val = it.val;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", 32'd0, 32'd0);
      finish_run();
    end
  end

  // Driver: launches a run and pushes the expected result.
  task automatic launch(input logic [31:0] b, input logic [31:0] e, input logic [31:0] n,
                        input logic [31:0] expv, input string tag);
    sb_item_t it;
    @(negedge clk);
    while (busy_o || done_o) @(negedge clk);
    start_i = 1'b1; base_i = b; exp_i = e; mod_i = n;
    it.val = expv; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", {31'd0, busy_o}, 32'd1);
  endtask

  task automatic wait_done();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [31:0] b, input logic [31:0] e, input logic [31:0] n, input string tag);
    launch(b, e, n, ref_pow(b, e, n), tag);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", {30'd0, busy_o, done_o}, 32'd0);
    chk(result_o == 32'd0, "R1", result_o, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && result_o == 32'd0, "R1", result_o, 32'd0);

    // R3: general operands
    run(32'd4, 32'd13, 32'd497, "R3");
    run(32'd123456, 32'd65537, 32'd1000003, "R3");
    run(32'd2, 32'd560, 32'd561, "R3");
    run(32'h1234_5678, 32'hDEAD_BEEF, 32'h7FFF_FFFF, "R3");

    // R4: exponent zero gives one
    launch(32'd77, 32'd0, 32'd101, 32'd1, "R4");
    wait_done();

    // R5: top exponent bit contributes
    run(32'd3, 32'h8000_0000, 32'd1000000007, "R5");
    run(32'd5, 32'h8000_0001, 32'd998244353, "R5");

    // R6: exponent one returns the base unchanged
    launch(32'd12345, 32'd1, 32'd65521, 32'd12345, "R6");
    wait_done();

    // R9: modulus near the word limit
    run(32'hFFFF_FFFA, 32'hFFFF_FFFF, 32'hFFFF_FFFB, "R9");
    run(32'hFFFF_FFF0, 32'h0000_0003, 32'hFFFF_FFFB, "R9");

    // R7: start raised mid-run with other operands is ignored
    launch(32'd9, 32'hF0F0_1234, 32'd100003, ref_pow(32'd9, 32'hF0F0_1234, 32'd100003), "R7");
    repeat (60) @(negedge clk);
    start_i = 1'b1; base_i = 32'd2; exp_i = 32'd5; mod_i = 32'd7;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7", {31'd0, busy_o}, 32'd1);
    wait_done();
    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R7", sbq.size(), 32'd0);

    // R8: output holds while inputs change without start
    base_i = 32'd1; exp_i = 32'd2; mod_i = 32'd3;
    repeat (30) @(negedge clk);
    chk(result_o == last_val, "R8", result_o, last_val);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R8", {30'd0, busy_o, done_o}, 32'd0);

    finish_run();
  end
endmodule